// File: doc/BRIEF.md
# Interrupt Recognition Timing Unit

This block is a cycle-accurate timing model of how a small 8-bit processor core notices a level-sensitive, active-low interrupt request and begins servicing it. It does not execute instructions. An external sequencer supplies a descriptor for each instruction: the cycle count, a conditional-branch flag and a branch-taken flag. The unit walks through the cycles of each instruction and decides when the request is polled. When the request is recognised, it runs the fixed seven-cycle entry sequence in place of the next instruction.

The request line is sampled late in each cycle, so an internal pending flag lags the line by one cycle. Ordinary instructions consult the pending flag in their last cycle. A conditional branch consults it in its second cycle, even when the branch is taken and runs a third cycle. Because of these two rules, the delay from a request to the start of service varies between 2 and 10 cycles.

The unit measures the total latency of every serviced request. This runs from the first cycle the line is low to the last entry cycle, inclusive, and is reported on a result port.

Top module: `irq_recog_unit`

## Requirements
- R1: The line is sampled once per cycle. When the line is low in cycle N, `pend` is 1 in cycle N+1. When the line is high in cycle N, `pend` is 0 in cycle N+1. The flag follows the line and is never latched.
- R2: An ordinary instruction (op_branch=0) polls `pend` in its last cycle. A request that first goes low in that last cycle is recognised only in the last cycle of the following instruction.
- R3: A conditional branch (op_branch=1) lasts 2 cycles when op_taken=0 and 3 cycles when op_taken=1. It always polls in its second cycle.
- R4: `op_take` is 1 in the first cycle of every instruction, and the descriptor inputs are sampled in that cycle. `op_cycles` is clamped into the range 2 to 8. `op_cycles` is ignored for branches.
- R5: Recognition happens when `poll` and `pend` are both 1 and `irq_mask` is 0 in the same cycle. After the last cycle of that instruction, a 7-cycle entry sequence follows, and `svc_enter` is 1 only in its first cycle. No poll and no `op_take` occur during the sequence. The next instruction starts in the cycle after it.
- R6: While `irq_mask` is 1, `pend` still follows the line, but no entry sequence starts.
- R7: If the line returns high early enough that `pend` is 0 at the poll, the request is lost and no entry sequence follows. If `pend` is still 1 at the poll, the request is serviced even though the line is already high.
- R8: `lat_valid` is 1 in the single cycle after the last entry cycle. At that time, `lat_cycles` equals the number of cycles from the first low cycle of the request through the last entry cycle, inclusive. This total is the wait plus 7. Unmasked, the wait spans 2 to 10 cycles, a jitter of 8.
- R9: A synchronous active-high `rst` clears `pend`, `svc_enter`, `lat_valid` and `lat_cycles`, and restarts in the first cycle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 1 | Interrupt request line, active low, synchronous to clk |
| irq_mask | input | 1 | Interrupt-disable flag; 1 blocks recognition |
| op_cycles | input | 4 | Cycle count of the instruction being started (clamped 2..8) |
| op_branch | input | 1 | Instruction is a conditional branch |
| op_taken | input | 1 | Branch is taken (3 cycles instead of 2) |
| op_take | output | 1 | First cycle of an instruction; descriptor sampled now |
| pend | output | 1 | Internal pending flag |
| poll | output | 1 | Polling cycle of the current instruction |
| svc_enter | output | 1 | First cycle of the entry sequence |
| lat_cycles | output | 8 | Total request-to-service latency of the last serviced request |
| lat_valid | output | 1 | One-cycle strobe marking a fresh `lat_cycles` value |

## Verification
The bench sweeps every descriptor type against every following-instruction length and every request cycle. This covers three cases. A request in a final cycle must spill into the next instruction; a design that polled one cycle too late would recognise it early. A request in the second cycle of a taken branch must wait through the whole next instruction; a design that polled a branch in its last cycle would report the worst case as 2 rather than 10. The pending delay must be a full cycle; a design without it would shorten every latency by one.

Directed runs cover the remaining cases. A masked request must never enter service. A one-cycle pulse is lost or kept depending on where it falls relative to the poll. Out-of-range counts must be clamped. Reset must return a busy unit to its initial state.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int LEN_MIN      = 2;
    localparam int LEN_MAX      = 8;
    localparam int ENTRY_CYCLES = 7;
    localparam int LEN_W        = $clog2(LEN_MAX + 1);
    localparam int ENT_W        = $clog2(ENTRY_CYCLES + 1);
    localparam int BR_SHORT     = 2;
    localparam int BR_LONG      = 3;
    localparam int BR_POLL      = 2;

    typedef enum logic [0:0] {
        PH_RUN   = 1'b0,
        PH_ENTRY = 1'b1
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] cycles;
        logic             branch;
        logic             taken;
    } op_desc_t;

    typedef struct packed {
        logic [LEN_W-1:0] last;
        logic [LEN_W-1:0] poll_at;
    } op_plan_t;

    function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] c);
        logic [LEN_W-1:0] r;
        r = c;
        if (r < LEN_W'(LEN_MIN)) r = LEN_W'(LEN_MIN);
        if (r > LEN_W'(LEN_MAX)) r = LEN_W'(LEN_MAX);
        return r;
    endfunction

    function automatic op_plan_t plan_op(op_desc_t d);
        op_plan_t p;
        if (d.branch) begin
            p.last    = d.taken ? LEN_W'(BR_LONG) : LEN_W'(BR_SHORT);
            p.poll_at = LEN_W'(BR_POLL);
        end else begin
            p.last    = clamp_len(d.cycles);
            p.poll_at = p.last;
        end
        return p;
    endfunction

endpackage

// File: rtl/irqt_sampler.sv
module irqt_sampler (
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    output logic pend
);
    // Late-cycle sample of the request line; visible in the next cycle.
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= ~irq_n;
    end
endmodule

// File: rtl/irqt_sequencer.sv
module irqt_sequencer
    import irqt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_desc_t desc,
    input  logic     pend,
    input  logic     mask,
    output logic     op_take,
    output logic     poll,
    output logic     svc_enter,
    output logic     rec_now,
    output logic     rec_held,
    output logic     in_entry,
    output logic     entry_last
);
    phase_e           phase;
    logic [LEN_W-1:0] pos;
    op_plan_t         plan_q;
    logic [ENT_W-1:0] ent_cnt;
    logic             last_cyc;

    assign in_entry   = (phase == PH_ENTRY);
    assign op_take    = (phase == PH_RUN) && (pos == LEN_W'(1));
    assign poll       = (phase == PH_RUN) && (pos != LEN_W'(1)) && (pos == plan_q.poll_at);
    assign last_cyc   = (phase == PH_RUN) && (pos != LEN_W'(1)) && (pos == plan_q.last);
    assign rec_now    = poll && pend && !mask;
    assign svc_enter  = in_entry && (ent_cnt == ENT_W'(1));
    assign entry_last = in_entry && (ent_cnt == ENT_W'(ENTRY_CYCLES));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_RUN;
            pos      <= LEN_W'(1);
            plan_q   <= '0;
            rec_held <= 1'b0;
            ent_cnt  <= '0;
        end else begin
            case (phase)
                PH_RUN: begin
                    if (op_take) plan_q <= plan_op(desc);
                    if (rec_now) rec_held <= 1'b1;
                    if (last_cyc) begin
                        pos <= LEN_W'(1);
                        if (rec_now || rec_held) begin
                            phase    <= PH_ENTRY;
                            ent_cnt  <= ENT_W'(1);
                            rec_held <= 1'b0;
                        end
                    end else begin
                        pos <= pos + LEN_W'(1);
                    end
                end
                PH_ENTRY: begin
                    if (entry_last) begin
                        phase   <= PH_RUN;
                        ent_cnt <= '0;
                    end else begin
                        ent_cnt <= ent_cnt + ENT_W'(1);
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/irqt_latency.sv
module irqt_latency #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_n,
    input  logic             in_entry,
    input  logic             entry_last,
    input  logic             rec_now,
    input  logic             rec_held,
    output logic [CNT_W-1:0] lat_cycles,
    output logic             lat_valid
);
    logic             tracking;
    logic [CNT_W-1:0] age;
    logic [CNT_W-1:0] age_inc;

    // Saturating increment so a long masked wait cannot wrap.
    assign age_inc = (&age) ? age : age + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tracking   <= 1'b0;
            age        <= '0;
            lat_cycles <= '0;
            lat_valid  <= 1'b0;
        end else begin
            lat_valid <= 1'b0;
            if (entry_last) begin
                lat_cycles <= age_inc;
                lat_valid  <= 1'b1;
                tracking   <= 1'b0;
                age        <= '0;
            end else if (in_entry) begin
                if (tracking) age <= age_inc;
            end else if (tracking) begin
                if (irq_n && !rec_now && !rec_held) begin
                    tracking <= 1'b0;
                    age      <= '0;
                end else begin
                    age <= age_inc;
                end
            end else if (!irq_n) begin
                tracking <= 1'b1;
                age      <= CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
    import irqt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_n,
    input  logic             irq_mask,
    input  logic [LEN_W-1:0] op_cycles,
    input  logic             op_branch,
    input  logic             op_taken,
    output logic             op_take,
    output logic             pend,
    output logic             poll,
    output logic             svc_enter,
    output logic [CNT_W-1:0] lat_cycles,
    output logic             lat_valid
);
    op_desc_t desc;
    logic     rec_now;
    logic     rec_held;
    logic     in_entry;
    logic     entry_last;

    assign desc = '{cycles: op_cycles, branch: op_branch, taken: op_taken};

    irqt_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .irq_n (irq_n),
        .pend  (pend)
    );

    irqt_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .desc       (desc),
        .pend       (pend),
        .mask       (irq_mask),
        .op_take    (op_take),
        .poll       (poll),
        .svc_enter  (svc_enter),
        .rec_now    (rec_now),
        .rec_held   (rec_held),
        .in_entry   (in_entry),
        .entry_last (entry_last)
    );

    irqt_latency #(.CNT_W(CNT_W)) u_lat (
        .clk        (clk),
        .rst        (rst),
        .irq_n      (irq_n),
        .in_entry   (in_entry),
        .entry_last (entry_last),
        .rec_now    (rec_now),
        .rec_held   (rec_held),
        .lat_cycles (lat_cycles),
        .lat_valid  (lat_valid)
    );
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
    import irqt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_n,
    input logic             op_take,
    input logic             pend,
    input logic             poll,
    input logic             svc_enter,
    input logic [CNT_W-1:0] lat_cycles,
    input logic             lat_valid
);
    logic [ENT_W-1:0] ent_left;

    always_ff @(posedge clk) begin
        if (rst)             ent_left <= '0;
        else if (svc_enter)  ent_left <= ENT_W'(ENTRY_CYCLES - 1);
        else if (ent_left != '0) ent_left <= ent_left - ENT_W'(1);
    end

    a_r1_low_sets_pend: assert property (@(posedge clk) disable iff (rst)
        !irq_n |=> pend);
    a_r1_high_clears_pend: assert property (@(posedge clk) disable iff (rst)
        irq_n |=> !pend);
    a_r4_no_poll_on_take: assert property (@(posedge clk) disable iff (rst)
        op_take |-> !poll);
    a_r5_entry_single_pulse: assert property (@(posedge clk) disable iff (rst)
        svc_enter |=> !svc_enter);
    a_r5_entry_quiet: assert property (@(posedge clk) disable iff (rst)
        (ent_left != '0) |-> (!poll && !op_take && !svc_enter));
    a_r8_latency_floor: assert property (@(posedge clk) disable iff (rst)
        lat_valid |-> (lat_cycles >= CNT_W'(LEN_MIN + ENTRY_CYCLES)));
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!pend && !svc_enter && !lat_valid && lat_cycles == '0));
endmodule

bind irq_recog_unit irqt_checker #(.CNT_W(CNT_W)) u_irqt_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_n      (irq_n),
    .op_take    (op_take),
    .pend       (pend),
    .poll       (poll),
    .svc_enter  (svc_enter),
    .lat_cycles (lat_cycles),
    .lat_valid  (lat_valid)
);

// File: tb/tb_irq_recog_unit.sv
`timescale 1ns/1ps
module tb_irq_recog_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_n = 1'b1;
    logic       irq_mask = 1'b0;
    logic [3:0] op_cycles = 4'd2;
    logic       op_branch = 1'b0;
    logic       op_taken = 1'b0;
    logic       op_take, pend, poll, svc_enter, lat_valid;
    logic [7:0] lat_cycles;

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;
    bit done = 0;

    // per-trial observations
    int svc_t, lat_t, lat_v, take_after, pend_k, pend_k1;
    int wmin = 100, wmax = 0;

    always #5 clk = ~clk;

    irq_recog_unit dut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .irq_mask(irq_mask),
        .op_cycles(op_cycles), .op_branch(op_branch), .op_taken(op_taken),
        .op_take(op_take), .pend(pend), .poll(poll), .svc_enter(svc_enter),
        .lat_cycles(lat_cycles), .lat_valid(lat_valid)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cyc_total);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(int c, int br, int tk);
        if (br != 0) return (tk != 0) ? 3 : 2;
        if (c < 2) return 2;
        if (c > 8) return 8;
        return c;
    endfunction

    function automatic int poll_pos(int c, int br, int tk);
        if (br != 0) return 2;
        return eff_len(c, br, tk);
    endfunction

    // One trial from reset. Request goes low in cycle k; pulse=0 holds it
    // until service entry, otherwise it stays low for pulse cycles.
    task automatic trial(input int c1, input int br1, input int tk1, input int l2,
                         input int k, input int pulse, input int msk, input int ncyc);
        int takes;
        @(negedge clk);
        rst = 1'b1; irq_n = 1'b1; irq_mask = 1'b0;
        @(negedge clk);
        rst = 1'b0; irq_mask = msk[0];
        takes = 0; svc_t = 0; lat_t = 0; lat_v = -1; take_after = 0;
        pend_k = -1; pend_k1 = -1;
        for (int t = 1; t <= ncyc; t++) begin
            if (svc_enter && svc_t == 0) svc_t = t;
            if (lat_valid && lat_t == 0) begin lat_t = t; lat_v = int'(lat_cycles); end
            if (op_take && svc_t != 0 && take_after == 0) take_after = t;
            if (t == k)     pend_k  = int'(pend);
            if (t == k + 1) pend_k1 = int'(pend);
            if (op_take) begin
                if (takes == 0) begin
                    op_cycles = 4'(c1); op_branch = br1[0]; op_taken = tk1[0];
                end else if (takes == 1) begin
                    op_cycles = 4'(l2); op_branch = 1'b0; op_taken = 1'b0;
                end else begin
                    op_cycles = 4'd2; op_branch = 1'b0; op_taken = 1'b0;
                end
                takes = takes + 1;
            end
            irq_n = !((t >= k) && (svc_t == 0) && (pulse == 0 || t < k + pulse));
            @(negedge clk);
        end
        irq_n = 1'b1;
    endtask

    initial begin
        int l1, p1, endc, w;
        string tag;
        repeat (3) @(negedge clk);

        // R9 reset state
        chk(pend == 1'b0 && svc_enter == 1'b0 && lat_valid == 1'b0 && lat_cycles == 8'd0,
            "R9 reset state", int'(lat_cycles), 0);
        chk(op_take == 1'b1, "R9/R4 op_take after reset", int'(op_take), 1);

        // Sweep: type 0 = branch not taken, 1 = branch taken, 2..8 = ordinary length
        for (int ty = 0; ty <= 8; ty++) begin
            for (int l2 = 2; l2 <= 8; l2++) begin
                int br, tk, c1;
                br = (ty < 2) ? 1 : 0;
                tk = (ty == 1) ? 1 : 0;
                c1 = (ty < 2) ? 5 : ty;
                l1 = eff_len(c1, br, tk);
                p1 = poll_pos(c1, br, tk);
                for (int k = 1; k <= l1; k++) begin
                    trial(c1, br, tk, l2, k, 0, 0, 24);
                    endc = (k < p1) ? l1 : l1 + l2;
                    w = endc - k + 1;
                    if (w < wmin) wmin = w;
                    if (w > wmax) wmax = w;
                    tag = (br != 0) ? "R3 branch entry cycle" : "R2 ordinary entry cycle";
                    chk(svc_t == endc + 1, tag, svc_t, endc + 1);
                    chk(lat_t == endc + 8 && lat_v == w + 7, "R8 latency value",
                        lat_v, w + 7);
                    chk(take_after == endc + 8, "R5 resume after entry", take_after, endc + 8);
                    chk(pend_k == 0 && pend_k1 == 1, "R1 pend one cycle late",
                        pend_k1, 1);
                end
            end
        end
        chk(wmin == 2, "R8 minimum wait", wmin, 2);
        chk(wmax == 10, "R8 maximum wait", wmax, 10);

        // R6 masked: pend follows, no entry
        trial(4, 0, 0, 4, 1, 0, 1, 24);
        chk(svc_t == 0, "R6 masked no entry", svc_t, 0);
        chk(pend_k1 == 1, "R6 masked pend follows", pend_k1, 1);

        // R7 lost pulse: low only in cycle 2 of a 5-cycle op
        trial(5, 0, 0, 5, 2, 1, 0, 24);
        chk(svc_t == 0 && lat_t == 0, "R7 lost pulse", svc_t, 0);
        // R7 kept pulse: low only in cycle 4, pend at poll in 5
        trial(5, 0, 0, 5, 4, 1, 0, 24);
        chk(svc_t == 6, "R7 kept pulse entry", svc_t, 6);
        chk(lat_v == 9, "R7 kept pulse latency", lat_v, 9);

        // R4 clamping and branch ignoring the count
        trial(0, 0, 0, 2, 1, 0, 0, 24);
        chk(svc_t == 3 && lat_v == 9, "R4 count 0 clamps to 2", lat_v, 9);
        trial(15, 0, 0, 2, 1, 0, 0, 24);
        chk(svc_t == 9 && lat_v == 15, "R4 count 15 clamps to 8", lat_v, 15);
        trial(15, 1, 1, 2, 1, 0, 0, 24);
        chk(svc_t == 4 && lat_v == 10, "R4 branch ignores count", lat_v, 10);

        // R9 reset from a busy state
        trial(4, 0, 0, 4, 1, 0, 0, 16);
        irq_n = 1'b0;
        @(negedge clk);
        chk(pend == 1'b1 && lat_cycles != 8'd0, "R9 busy before reset", int'(pend), 1);
        rst = 1'b1; irq_n = 1'b1;
        @(negedge clk);
        chk(pend == 1'b0 && svc_enter == 1'b0 && lat_valid == 1'b0 && lat_cycles == 8'd0,
            "R9 reset clears", int'(lat_cycles), 0);
        rst = 1'b0;
        chk(op_take == 1'b1, "R9 restart at first cycle", int'(op_take), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule